// File: doc/BRIEF.md
# Halfword Control Register Bank

This block holds the 16-bit control registers that sit behind a small memory-mapped window. Bus accesses may be 8, 16 or 32 bits wide. Every access is turned into halfword operations on the stored array. A word access becomes two adjacent halfword operations. A byte write first merges the new byte with the other byte of the stored halfword. Each halfword then passes through its own access rule before it is stored.

The access rules are these. Most registers apply a write mask, so bits outside the mask are stored as zero. The interrupt-flag register clears the bits written as one. A few locations are write-only and read back as zero. The key-state location is computed at read time from an active-high pressed-key vector. A byte-wide trigger location produces a halt or stop pulse and is never stored. Reads are combinational from the array. The engines that consume these registers are not part of this block.

Top module: `io_reg_bank`

## Requirements
- R1: After reset, halfword reads return 0x0080 at 0x000, 0x0200 at 0x088 and 0x03FF at 0x130 (no keys pressed), and 0 at every other location; ie_o, if_o, halt_req_o and stop_req_o are 0.
- R2: A write to 0x004 is stored ANDed with 0xFFF8.
- R3: Writes to the timer control locations 0x102, 0x106, 0x10A and 0x10E are stored ANDed with 0x00C7. A write to the serial mode location 0x134 is stored ANDed with 0xC1FF.
- R4: The audio locations store written data ANDed with these masks: 0x060 0x00FF, 0x064 0x47FF, 0x06C 0x47FF, 0x070 0x00E0, 0x072 0xE000, 0x074 0x43FF, 0x078 0xFF00, 0x07C 0x40FF.
- R5: For the flag register at 0x202, each write-data bit that is 1 clears the matching stored bit. A bit of irq_set_i that is 1 sets the matching stored bit, and a set wins over a clear in the same cycle.
- R6: A byte write (size_i = 0) carries its byte in wdata_i[7:0]. The byte goes into the upper lane when addr_i[0] is 1 and into the lower lane otherwise; the other lane keeps its stored byte. The merged halfword then follows the target's mask or clear rule, so at 0x202 any set bits in the other byte are cleared too.
- R7: A byte write to 0x301 stores nothing. On the clock edge that takes the write, halt_req_o goes high for one cycle if wdata_i[7] is 0, and stop_req_o goes high for one cycle if wdata_i[7] is 1. The two pulses are never high together.
- R8: Halfword reads of the write-only count locations 0x0B8, 0x0C4, 0x0D0 and 0x0DC return 0, even after a write to them.
- R9: A halfword read of 0x130 returns 0x03FF XOR keys_i, and writes to 0x130 have no effect.
- R10: A word write (size_i = 2) ignores addr_i[1:0]. It writes wdata_i[15:0] to the aligned address and wdata_i[31:16] to the aligned address + 2, with each half following its own rule. A word read returns {halfword at +2, halfword at the aligned address}.
- R11: Writes to unmapped locations (for example 0x05A, 0x150 and 0x206) are ignored, and reads of them return 0.
- R12: Writes take effect at the rising clock edge while we_i is high, and stored values do not change otherwise. Read data follows addr_i and size_i without a clock. ie_o is the stored value at 0x200 and if_o is the stored value at 0x202.
- R13: A plain mapped location such as 0x008 stores all 16 written bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Byte address of the access |
| size_i | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| wdata_i | input | 32 | Write data (byte in [7:0], halfword in [15:0]) |
| we_i | input | 1 | Write strobe |
| keys_i | input | 10 | Pressed-key vector, 1 = pressed |
| irq_set_i | input | 16 | Hardware interrupt flag set bits |
| rdata_o | output | 32 | Combinational read data |
| ie_o | output | 16 | Interrupt enable register |
| if_o | output | 16 | Interrupt flag register |
| halt_req_o | output | 1 | One-cycle halt request pulse |
| stop_req_o | output | 1 | One-cycle stop request pulse |

## Verification
Some properties are checked on every cycle by the assertions. A register keeps its value in any cycle with no write and no set. A flag write always leaves the written-one bits clear. Halt and stop never pulse together. The write-only count location and the upper key bits always read as zero. A word write to the enable register lands its low half. The bench scenarios are needed for the rest. They cover the per-location mask values and the byte-lane merge. They also cover the cross-lane clear that a byte write to the flag register causes, the ordering of a set and a clear in one cycle, and the exact cycle of the halt and stop pulses.

// File: rtl/io_bank_pkg.sv
`timescale 1ns/1ps
package io_bank_pkg;

  typedef enum logic [1:0] {
    ACC_BYTE = 2'd0,
    ACC_HALF = 2'd1,
    ACC_WORD = 2'd2
  } acc_size_e;

  localparam int unsigned IE_ADDR   = 32'h200;
  localparam int unsigned IF_ADDR   = 32'h202;
  localparam int unsigned KEY_ADDR  = 32'h130;
  localparam int unsigned HALT_ADDR = 32'h301;

  // write mask per byte address; 0 means nothing is stored
  function automatic logic [15:0] hw_mask(int unsigned a);
    case (a)
      32'h004:                            return 16'hFFF8;
      32'h060:                            return 16'h00FF;
      32'h064, 32'h06C:                   return 16'h47FF;
      32'h070:                            return 16'h00E0;
      32'h072:                            return 16'hE000;
      32'h074:                            return 16'h43FF;
      32'h078:                            return 16'hFF00;
      32'h07C:                            return 16'h40FF;
      32'h102, 32'h106, 32'h10A, 32'h10E: return 16'h00C7;
      32'h134:                            return 16'hC1FF;
      32'h0B8, 32'h0C4, 32'h0D0, 32'h0DC: return 16'h0000;
      32'h130:                            return 16'h0000;
      default: begin
        if (a inside {[32'h000:32'h056], [32'h060:32'h0A6], [32'h0B0:32'h0DE],
                      [32'h100:32'h10E], [32'h120:32'h12A], [32'h130:32'h134],
                      [32'h200:32'h204], 32'h208})
          return 16'hFFFF;
        return 16'h0000;
      end
    endcase
  endfunction

  function automatic logic [15:0] hw_reset(int unsigned a);
    case (a)
      32'h000: return 16'h0080;
      32'h088: return 16'h0200;
      default: return 16'h0000;
    endcase
  endfunction

endpackage

// File: rtl/io_reg_slot.sv
`timescale 1ns/1ps
module io_reg_slot #(
  parameter logic [15:0] MASK = 16'hFFFF,
  parameter logic [15:0] RST  = 16'h0000,
  parameter bit          W1C  = 1'b0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [15:0] wd_i,
  input  logic [15:0] set_i,
  output logic [15:0] q_o
);

  logic [15:0] q_d;

  always_comb begin
    if (W1C) q_d = ((q_o & ~(we_i ? wd_i : 16'h0)) | set_i) & MASK;
    else     q_d = ((we_i ? wd_i : q_o) | set_i) & MASK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= RST;
    else if (we_i || set_i != 16'h0) q_o <= q_d;
  end

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && set_i == 16'h0) |=> $stable(q_o)); // R12

  if (W1C) begin : g_w1c_chk
    AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && set_i == 16'h0) |=> ((q_o & $past(wd_i)) == 16'h0)); // R5
  end

endmodule

// File: rtl/io_write_split.sv
`timescale 1ns/1ps
module io_write_split
  import io_bank_pkg::*;
#(
  parameter int ADDR_W = 10,
  localparam int IDX_W = ADDR_W - 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic [31:0]       wdata_i,
  input  logic              we_i,
  input  logic [15:0]       cur_hw_i,
  output logic              lo_en_o,
  output logic [IDX_W-1:0]  lo_idx_o,
  output logic [15:0]       lo_data_o,
  output logic              hi_en_o,
  output logic [IDX_W-1:0]  hi_idx_o,
  output logic [15:0]       hi_data_o,
  output logic              halt_o,
  output logic              stop_o
);

  logic is_byte, is_word, trig_sel;

  always_comb begin
    is_byte  = (size_i == ACC_BYTE);
    is_word  = (size_i == ACC_WORD);
    trig_sel = is_byte && (addr_i == ADDR_W'(HALT_ADDR));

    lo_en_o  = we_i && !trig_sel;
    lo_idx_o = is_word ? {addr_i[ADDR_W-1:2], 1'b0} : addr_i[ADDR_W-1:1];
    if (is_byte)
      lo_data_o = addr_i[0] ? {wdata_i[7:0], cur_hw_i[7:0]} : {cur_hw_i[15:8], wdata_i[7:0]};
    else
      lo_data_o = wdata_i[15:0];

    hi_en_o   = we_i && is_word;
    hi_idx_o  = lo_idx_o + IDX_W'(1);
    hi_data_o = wdata_i[31:16];

    halt_o = we_i && trig_sel && !wdata_i[7];
    stop_o = we_i && trig_sel &&  wdata_i[7];
  end

endmodule

// File: rtl/io_read_mux.sv
`timescale 1ns/1ps
module io_read_mux
  import io_bank_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int NUM_HW = 262,
  localparam int IDX_W = ADDR_W - 1
) (
  input  logic [NUM_HW-1:0][15:0] regs_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [1:0]              size_i,
  input  logic [9:0]              keys_i,
  output logic [31:0]             rdata_o
);

  function automatic logic [15:0] hw_at(logic [IDX_W-1:0] i);
    if (i == IDX_W'(KEY_ADDR / 2)) return 16'h03FF ^ {6'h0, keys_i};
    if (32'(i) < NUM_HW)           return regs_i[i];
    return 16'h0;
  endfunction

  logic [IDX_W-1:0] idx;
  logic [15:0]      lo_hw, hi_hw;

  always_comb begin
    idx   = (size_i == ACC_WORD) ? {addr_i[ADDR_W-1:2], 1'b0} : addr_i[ADDR_W-1:1];
    lo_hw = hw_at(idx);
    hi_hw = hw_at(idx + IDX_W'(1));
    case (size_i)
      ACC_BYTE: rdata_o = {24'h0, addr_i[0] ? lo_hw[15:8] : lo_hw[7:0]};
      ACC_WORD: rdata_o = {hi_hw, lo_hw};
      default:  rdata_o = {16'h0, lo_hw};
    endcase
  end

endmodule

// File: rtl/io_reg_bank.sv
`timescale 1ns/1ps
module io_reg_bank
  import io_bank_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int NUM_HW = 262
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic [31:0]       wdata_i,
  input  logic              we_i,
  input  logic [9:0]        keys_i,
  input  logic [15:0]       irq_set_i,
  output logic [31:0]       rdata_o,
  output logic [15:0]       ie_o,
  output logic [15:0]       if_o,
  output logic              halt_req_o,
  output logic              stop_req_o
);

  localparam int IDX_W = ADDR_W - 1;

  logic [NUM_HW-1:0][15:0] regs;
  logic                    lo_en, hi_en, halt_hit, stop_hit;
  logic [IDX_W-1:0]        lo_idx, hi_idx;
  logic [15:0]             lo_data, hi_data, cur_hw;

  assign cur_hw = (32'(lo_idx) < NUM_HW) ? regs[lo_idx] : 16'h0;

  io_write_split #(.ADDR_W(ADDR_W)) u_split (
    .addr_i    (addr_i),
    .size_i    (size_i),
    .wdata_i   (wdata_i),
    .we_i      (we_i),
    .cur_hw_i  (cur_hw),
    .lo_en_o   (lo_en),
    .lo_idx_o  (lo_idx),
    .lo_data_o (lo_data),
    .hi_en_o   (hi_en),
    .hi_idx_o  (hi_idx),
    .hi_data_o (hi_data),
    .halt_o    (halt_hit),
    .stop_o    (stop_hit)
  );

  for (genvar k = 0; k < NUM_HW; k++) begin : g_hw
    localparam logic [15:0] M      = hw_mask(2 * k);
    localparam bit          IS_FLG = (2 * k == IF_ADDR);
    if (M != 16'h0) begin : g_slot
      logic hit_lo, hit_hi;
      assign hit_lo = lo_en && (lo_idx == IDX_W'(k));
      assign hit_hi = hi_en && (hi_idx == IDX_W'(k));
      io_reg_slot #(.MASK(M), .RST(hw_reset(2 * k)), .W1C(IS_FLG)) u_slot (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .we_i   (hit_lo || hit_hi),
        .wd_i   (hit_hi ? hi_data : lo_data),
        .set_i  (IS_FLG ? irq_set_i : 16'h0),
        .q_o    (regs[k])
      );
    end else begin : g_none
      assign regs[k] = 16'h0;
    end
  end

  io_read_mux #(.ADDR_W(ADDR_W), .NUM_HW(NUM_HW)) u_rd (
    .regs_i  (regs),
    .addr_i  (addr_i),
    .size_i  (size_i),
    .keys_i  (keys_i),
    .rdata_o (rdata_o)
  );

  assign ie_o = regs[IE_ADDR / 2];
  assign if_o = regs[IF_ADDR / 2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halt_req_o <= 1'b0;
      stop_req_o <= 1'b0;
    end else begin
      halt_req_o <= halt_hit;
      stop_req_o <= stop_hit;
    end
  end

  AST_TRIG_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(halt_req_o && stop_req_o)); // R7

  AST_WO_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (size_i == ACC_HALF && addr_i == ADDR_W'(32'h0B8)) |-> (rdata_o == 32'h0)); // R8

  AST_KEY_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (size_i == ACC_HALF && addr_i == ADDR_W'(KEY_ADDR)) |-> (rdata_o[31:10] == 22'h0)); // R9

  AST_WORD_LOW_HALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && size_i == ACC_WORD && addr_i[ADDR_W-1:2] == (ADDR_W-2)'(IE_ADDR >> 2))
    |=> (ie_o == $past(wdata_i[15:0]))); // R10

endmodule

// File: tb/io_reg_bank_test.sv
`timescale 1ns/1ps
module io_reg_bank_test;

  localparam int ADDR_W = 10;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [1:0]        size_i = 2'd1;
  logic [31:0]       wdata_i = '0;
  logic              we_i = 1'b0;
  logic [9:0]        keys_i = '0;
  logic [15:0]       irq_set_i = '0;
  logic [31:0]       rdata_o;
  logic [15:0]       ie_o, if_o;
  logic              halt_req_o, stop_req_o;

  io_reg_bank #(.ADDR_W(ADDR_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr_i), .size_i(size_i),
    .wdata_i(wdata_i), .we_i(we_i), .keys_i(keys_i), .irq_set_i(irq_set_i),
    .rdata_o(rdata_o), .ie_o(ie_o), .if_o(if_o),
    .halt_req_o(halt_req_o), .stop_req_o(stop_req_o)
  );

  always #2.5 clk = ~clk;

  localparam logic [1:0] SZ_B = 2'd0, SZ_H = 2'd1, SZ_W = 2'd2;
  localparam int K_RD = 0, K_IE = 1, K_IF = 2, K_HALT = 3, K_STOP = 4;

  int          checks = 0;
  int          failures = 0;
  bit          done = 1'b0;
  int          kind_q[$];
  logic [31:0] exp_q[$];
  string       tag_q[$];
  event        sample_ev;

  // monitor: pops expected items and compares against outputs
  initial begin
    forever begin
      @(sample_ev);
      while (kind_q.size() > 0) begin
        int          k;
        logic [31:0] e, a;
        string       t;
        k = kind_q.pop_front();
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        case (k)
          K_RD:    a = rdata_o;
          K_IE:    a = {16'h0, ie_o};
          K_IF:    a = {16'h0, if_o};
          K_HALT:  a = {31'h0, halt_req_o};
          default: a = {31'h0, stop_req_o};
        endcase
        checks++;
        if (a !== e) begin
          failures++;
          $display("FAIL %s actual=%h expected=%h", t, a, e);
        end
      end
    end
  end

  task automatic expect_now(int kind, logic [31:0] e, string t);
    #1;
    kind_q.push_back(kind);
    exp_q.push_back(e);
    tag_q.push_back(t);
    ->sample_ev;
    #0.5;
  endtask

  task automatic wr(int a, logic [1:0] sz, logic [31:0] d, logic [15:0] s = 16'h0);
    @(negedge clk);
    addr_i = ADDR_W'(a); size_i = sz; wdata_i = d; we_i = 1'b1; irq_set_i = s;
    @(negedge clk);
    we_i = 1'b0; irq_set_i = 16'h0;
  endtask

  task automatic set_irq(logic [15:0] s);
    @(negedge clk);
    irq_set_i = s;
    @(negedge clk);
    irq_set_i = 16'h0;
  endtask

  task automatic rd(int a, logic [1:0] sz, logic [31:0] e, string t);
    @(negedge clk);
    addr_i = ADDR_W'(a); size_i = sz; we_i = 1'b0;
    expect_now(K_RD, e, t);
  endtask

  task automatic out(int kind, logic [31:0] e, string t);
    @(negedge clk);
    expect_now(kind, e, t);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  int          snd_a[8] = '{32'h060, 32'h064, 32'h06C, 32'h070, 32'h072, 32'h074, 32'h078, 32'h07C};
  logic [15:0] snd_m[8] = '{16'h00FF, 16'h47FF, 16'h47FF, 16'h00E0, 16'hE000, 16'h43FF, 16'hFF00, 16'h40FF};

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    rd(32'h000, SZ_H, 32'h0080, "R1 reset display ctrl");
    rd(32'h088, SZ_H, 32'h0200, "R1 reset sound bias");
    rd(32'h130, SZ_H, 32'h03FF, "R1 reset key");
    rd(32'h008, SZ_H, 32'h0000, "R1 reset plain");
    out(K_IE, 0, "R1 reset ie");
    out(K_IF, 0, "R1 reset if");
    out(K_HALT, 0, "R1 reset halt");
    out(K_STOP, 0, "R1 reset stop");

    // R13 plain halfword
    wr(32'h008, SZ_H, 32'hBEEF);
    rd(32'h008, SZ_H, 32'hBEEF, "R13 plain store");

    // R2 / R3 masks
    wr(32'h004, SZ_H, 32'hFFFF);
    rd(32'h004, SZ_H, 32'hFFF8, "R2 status mask");
    wr(32'h106, SZ_H, 32'hFFFF);
    rd(32'h106, SZ_H, 32'h00C7, "R3 timer ctrl mask");
    wr(32'h10E, SZ_H, 32'h1234);
    rd(32'h10E, SZ_H, 32'h0004, "R3 timer ctrl mask 2");
    wr(32'h134, SZ_H, 32'hFFFF);
    rd(32'h134, SZ_H, 32'hC1FF, "R3 serial mode mask");

    // R4 audio masks
    for (int i = 0; i < 8; i++) begin
      wr(snd_a[i], SZ_H, 32'hFFFF);
      rd(snd_a[i], SZ_H, {16'h0, snd_m[i]}, "R4 audio mask");
    end

    // R8 write-only
    wr(32'h0C4, SZ_H, 32'h1234);
    rd(32'h0C4, SZ_H, 32'h0, "R8 write-only reads zero");
    wr(32'h0B8, SZ_H, 32'hFFFF);
    rd(32'h0B8, SZ_H, 32'h0, "R8 write-only reads zero 2");

    // R9 keys
    keys_i = 10'h005;
    rd(32'h130, SZ_H, 32'h03FA, "R9 key active low");
    keys_i = 10'h3FF;
    wr(32'h130, SZ_H, 32'hFFFF);
    rd(32'h130, SZ_H, 32'h0000, "R9 key all pressed, write ignored");
    keys_i = 10'h000;

    // R6 byte merge
    wr(32'h009, SZ_B, 32'h12);
    rd(32'h008, SZ_H, 32'h12EF, "R6 upper lane merge");
    wr(32'h008, SZ_B, 32'h34);
    rd(32'h008, SZ_H, 32'h1234, "R6 lower lane merge");
    rd(32'h009, SZ_B, 32'h12, "R6 byte read upper");
    wr(32'h004, SZ_B, 32'h00);
    rd(32'h004, SZ_H, 32'hFF00, "R6 byte then mask");

    // R10 word split
    wr(32'h010, SZ_W, 32'hCAFE1234);
    rd(32'h010, SZ_H, 32'h1234, "R10 word low half");
    rd(32'h012, SZ_H, 32'hCAFE, "R10 word high half");
    rd(32'h013, SZ_W, 32'hCAFE1234, "R10 word read unaligned");

    // R5 flags
    set_irq(16'h00F3);
    out(K_IF, 32'h00F3, "R5 hardware set");
    wr(32'h202, SZ_H, 32'h0031);
    out(K_IF, 32'h00C2, "R5 write one clears");
    wr(32'h202, SZ_H, 32'h0001, 16'h0001);
    out(K_IF, 32'h00C3, "R5 set beats clear");
    set_irq(16'h0300);
    wr(32'h202, SZ_B, 32'h01);
    out(K_IF, 32'h00C2, "R6 byte to flags clears other lane");

    // R10 / R12 word over enable and flags
    wr(32'h200, SZ_W, 32'h0080_0055);
    out(K_IE, 32'h0055, "R12 ie output");
    out(K_IF, 32'h0042, "R10 word high half to flags");
    rd(32'h200, SZ_W, 32'h0042_0055, "R10 word read");

    // R7 trigger
    wr(32'h301, SZ_B, 32'h00);
    expect_now(K_HALT, 1, "R7 halt pulse");
    expect_now(K_STOP, 0, "R7 no stop on halt");
    out(K_HALT, 0, "R7 halt one cycle");
    wr(32'h301, SZ_B, 32'h80);
    expect_now(K_STOP, 1, "R7 stop pulse");
    expect_now(K_HALT, 0, "R7 no halt on stop");
    out(K_STOP, 0, "R7 stop one cycle");
    rd(32'h300, SZ_H, 32'h0, "R7 trigger not stored");

    // R11 unmapped
    wr(32'h150, SZ_H, 32'hFFFF);
    rd(32'h150, SZ_H, 32'h0, "R11 unmapped 0x150");
    wr(32'h206, SZ_H, 32'hFFFF);
    rd(32'h206, SZ_H, 32'h0, "R11 unmapped 0x206");
    wr(32'h05A, SZ_H, 32'hFFFF);
    rd(32'h05A, SZ_H, 32'h0, "R11 unmapped 0x05A");
    rd(32'h008, SZ_H, 32'h1234, "R12 neighbour unchanged");

    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule